// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects sixteen maskable interrupt sources and one non-maskable line, and reports the most urgent pending request to the processor as a 4-bit priority code. The sources are six external lines whose trigger style is programmable, four active-low level lines, four on-chip event lines (tick timer, general timer, watchdog, bus error) and two software requests. Each source carries its own programmable priority from 1 to 15. Code 15 is the most urgent. Code 0 means the source never raises a request.

Edge-style sources latch into a pending bit. The bit stays set until software writes a one to it, and it ignores further edges until then. Level-style sources are pending for as long as their input is held low. A per-source enable mask gates what reaches the request output, while the pending register always shows the raw state. The non-maskable line bypasses the mask and the priority logic. A simple synchronous write port and a combinational read port give access to the configuration.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_req_o` and `nmi_req_o` are low and `irq_level_o` is 0, provided the inputs are idle (external and low lines high, events and NMI low).
- R2: Register addresses are: 0 = trigger style (bits 5:0, 1 = edge, for external line n at bit n), 1 = enable mask (bits 15:0), 2 = pending (read status, write one to clear), 3 = software set (bits 1:0, write-only, reads zero), 4 and 5 = priority map (4 bits per source, source s at address 4 + s/8, bits 4*(s%8)+3 : 4*(s%8)). Bits outside these fields read zero. Source bit order is: external 0–5, low lines 6–9, events 10–13, software 14–15.
- R3: An external line in level style (style bit 0) is pending while its pin is low. The pin passes through two synchronizer flops, so the status changes two clocks after the pin changes.
- R4: The four low lines are always level-triggered and active low, whatever is in the trigger-style register, with the same two-clock latency.
- R5: An external line in edge style latches its pending bit on a rising pin edge, three clocks after the pin rises. The bit stays set after the pin falls. A low pin in edge style raises nothing.
- R6: Writing a one to a pending bit clears an edge-latched or software bit on that clock. Writing to the bit of a source in level style has no effect while that source is still active.
- R7: While a latched bit is set, new trigger edges on that source are not recorded. An edge arriving in the same clock as the clear write is lost as well.
- R8: The event lines are on-chip and are not synchronized. A rising edge latches the bit one clock later, and an event held high latches only once.
- R9: Writing a one to bit 0 or bit 1 of the software-set register sets pending bit 14 or 15 respectively.
- R10: `irq_level_o` is the highest priority code among pending, enabled sources. `irq_req_o` is high exactly when that code is non-zero, so a source mapped to 0 never requests.
- R11: The enable mask gates only the request output. The pending register shows sources regardless of the mask.
- R12: `nmi_req_o` follows `nmi_i` two clocks later, independent of the mask and of the priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 6 | External interrupt lines, trigger style programmable |
| low_irq_n_i | input | 4 | Active-low level interrupt lines |
| evt_i | input | 4 | On-chip events: tick, timer, watchdog, bus error |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| irq_req_o | output | 1 | Maskable interrupt request |
| irq_level_o | output | 4 | Priority code of the most urgent request |
| nmi_req_o | output | 1 | Non-maskable interrupt request |

## Verification
A latched bit that is wrongly set or lost shows up in the pending readback within one clock and, if the source is enabled with a non-zero code, on `irq_level_o` in the same cycle. A wrong priority compare only shows when two or more differently mapped sources are pending together, so the scenarios stack sources and then remove them one at a time. Re-trigger and same-cycle clear bugs leave no trace until after the next clear, so they are checked by reading the pending bit after the clear.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int N_EXT  = 6;
  localparam int N_LOW  = 4;
  localparam int N_EVT  = 4;
  localparam int N_SW   = 2;
  localparam int N_SRC  = N_EXT + N_LOW + N_EVT + N_SW;
  localparam int LVL_W  = 4;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int MAP_PER_REG = DATA_W / LVL_W;
  localparam int MAP_REGS    = (N_SRC + MAP_PER_REG - 1) / MAP_PER_REG;

  localparam logic [ADDR_W-1:0] ADR_STYLE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PEND  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SWSET = 3'd3;
  localparam int                MAP_BASE  = 4;

  // Highest priority code among active sources; 0 when none.
  function automatic logic [LVL_W-1:0] top_level(
    input logic [N_SRC-1:0]       act,
    input logic [N_SRC*LVL_W-1:0] map
  );
    logic [LVL_W-1:0] best;
    logic [LVL_W-1:0] cur;
    best = '0;
    for (int i = 0; i < N_SRC; i++) begin
      cur = map[i*LVL_W +: LVL_W];
      if (act[i] && (cur > best)) best = cur;
    end
    return best;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W       = 1,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_ONE}};
      q    <= {W{RST_ONE}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_sync,
  input  logic [N_LOW-1:0] low_sync,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EXT-1:0] edge_style,
  input  logic [N_SW-1:0]  sw_set,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] rise,
  output logic [N_SRC-1:0] latch,
  output logic [N_SRC-1:0] pend
);
  logic [N_EXT-1:0] ext_q;
  logic [N_EVT-1:0] evt_q;
  logic [N_SRC-1:0] keep;
  logic [N_SRC-1:0] level_act;
  logic [N_SRC-1:0] latch_nxt;

  always_comb begin
    rise      = {sw_set, evt & ~evt_q, {N_LOW{1'b0}}, edge_style & ext_sync & ~ext_q};
    keep      = {{(N_SW + N_EVT){1'b1}}, {N_LOW{1'b0}}, edge_style};
    level_act = {{(N_SW + N_EVT){1'b0}}, ~low_sync, ~edge_style & ~ext_sync};
    // set bits hold until cleared; clear wins; new edge only on a clear bit
    latch_nxt = ((latch & ~clr) | (~latch & rise)) & keep;
    pend      = latch | level_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '1;
      evt_q <= '0;
      latch <= '0;
    end else begin
      ext_q <= ext_sync;
      evt_q <= evt;
      latch <= latch_nxt;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import prio_irq_pkg::*;
(
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC-1:0]       en,
  input  logic [N_SRC*LVL_W-1:0] map,
  output logic                   req,
  output logic [LVL_W-1:0]       level
);
  always_comb begin
    level = top_level(pend & en, map);
    req   = |level;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic [N_LOW-1:0]  low_irq_n_i,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              nmi_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              irq_req_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic              nmi_req_o
);
  logic [N_EXT-1:0]          style_q;
  logic [N_SRC-1:0]          en_q;
  logic [N_SRC*LVL_W-1:0]    map_q;
  logic [N_EXT-1:0]          ext_sync;
  logic [N_LOW-1:0]          low_sync;
  logic [N_SRC-1:0]          clr_w1c;
  logic [N_SW-1:0]           sw_pulse;
  logic [N_SRC-1:0]          rise_vec;
  logic [N_SRC-1:0]          edge_latch;
  logic [N_SRC-1:0]          pend_vec;

  irq_sync #(.W(N_EXT), .RST_ONE(1'b1)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .d(ext_irq_i), .q(ext_sync));
  irq_sync #(.W(N_LOW), .RST_ONE(1'b1)) u_sync_low (
    .clk(clk), .rst_n(rst_n), .d(low_irq_n_i), .q(low_sync));
  irq_sync #(.W(1), .RST_ONE(1'b0)) u_sync_nmi (
    .clk(clk), .rst_n(rst_n), .d(nmi_i), .q(nmi_req_o));

  always_comb begin
    clr_w1c  = (cfg_wr_i && cfg_addr_i == ADR_PEND)  ? cfg_wdata_i[N_SRC-1:0] : '0;
    sw_pulse = (cfg_wr_i && cfg_addr_i == ADR_SWSET) ? cfg_wdata_i[N_SW-1:0]  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= '0;
      en_q    <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_addr_i == ADR_STYLE) style_q <= cfg_wdata_i[N_EXT-1:0];
      if (cfg_addr_i == ADR_MASK)  en_q    <= cfg_wdata_i[N_SRC-1:0];
    end
  end

  for (genvar r = 0; r < MAP_REGS; r++) begin : g_map
    localparam int LO = r * DATA_W;
    localparam int HI = (LO + DATA_W > N_SRC * LVL_W) ? N_SRC * LVL_W : LO + DATA_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[HI-1:LO] <= '0;
      else if (cfg_wr_i && cfg_addr_i == ADDR_W'(MAP_BASE + r))
        map_q[HI-1:LO] <= cfg_wdata_i[HI-LO-1:0];
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == ADR_STYLE) cfg_rdata_o[N_EXT-1:0] = style_q;
    if (cfg_addr_i == ADR_MASK)  cfg_rdata_o[N_SRC-1:0] = en_q;
    if (cfg_addr_i == ADR_PEND)  cfg_rdata_o[N_SRC-1:0] = pend_vec;
    for (int r = 0; r < MAP_REGS; r++)
      if (cfg_addr_i == ADDR_W'(MAP_BASE + r))
        cfg_rdata_o = map_q[r*DATA_W +: DATA_W];
  end

  irq_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .ext_sync(ext_sync), .low_sync(low_sync), .evt(evt_i),
    .edge_style(style_q), .sw_set(sw_pulse), .clr(clr_w1c),
    .rise(rise_vec), .latch(edge_latch), .pend(pend_vec));

  irq_prio u_prio (
    .pend(pend_vec), .en(en_q), .map(map_q),
    .req(irq_req_o), .level(irq_level_o));
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] clr,
  input logic [N_SRC-1:0] rise,
  input logic [N_SRC-1:0] latch,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] en,
  input logic [N_EXT-1:0] style,
  input logic             irq_req,
  input logic [LVL_W-1:0] irq_level
);
  logic [N_SRC-1:0] keep;
  assign keep = {{(N_SRC - N_EXT){1'b1}}, style};

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) & latch) == '0);

  // R7
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latch) & ~$past(clr) & $past(keep) & keep & ~latch) == '0);

  // R5
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rise) & ~$past(latch) & $past(keep) & keep & ~latch) == '0);

  // R11
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend & en) != '0));

  // R10
  no_enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (irq_level == '0 && !irq_req));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr_w1c), .rise(rise_vec),
  .latch(edge_latch), .pend(pend_vec), .en(en_q), .style(style_q),
  .irq_req(irq_req_o), .irq_level(irq_level_o));

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ext_irq = 6'h3F;
  logic [3:0]  low_n = 4'hF;
  logic [3:0]  evt = 4'h0;
  logic        nmi = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic        nmi_req;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] lv [16];

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .low_irq_n_i(low_n),
    .evt_i(evt), .nmi_i(nmi), .cfg_wr_i(wr), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_req_o(irq_req),
    .irq_level_o(irq_level), .nmi_req_o(nmi_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic set_lvl(input int src, input logic [3:0] l);
    logic [31:0] w;
    lv[src] = l;
    w = '0;
    for (int k = 0; k < 8; k++) w[k*4 +: 4] = lv[(src/8)*8 + k];
    wr_reg(3'(4 + src/8), w);
  endtask

  task automatic chk_pend(input string req, input int bitn, input logic exp);
    logic [31:0] d;
    rd_reg(3'd2, d);
    chk(req, {31'b0, d[bitn]}, {31'b0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), d);
      chk("R1 register reset", d, 32'h0);
    end
    chk("R1 irq_req reset", {31'b0, irq_req}, 32'h0);
    chk("R1 level reset", {28'b0, irq_level}, 32'h0);
    chk("R1 nmi reset", {31'b0, nmi_req}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr_reg(3'd0, 32'h0000_002A); rd_reg(3'd0, d); chk("R2 style readback", d, 32'h2A);
    wr_reg(3'd0, 32'hFFFF_FFC0); rd_reg(3'd0, d); chk("R2 style upper bits", d, 32'h0);
    wr_reg(3'd1, 32'h1234_ABCD); rd_reg(3'd1, d); chk("R2 mask readback", d, 32'h0000_ABCD);
    wr_reg(3'd4, 32'h8765_4321); rd_reg(3'd4, d); chk("R2 map0 readback", d, 32'h8765_4321);
    wr_reg(3'd5, 32'h0FED_CBA9); rd_reg(3'd5, d); chk("R2 map1 readback", d, 32'h0FED_CBA9);
    rd_reg(3'd3, d); chk("R2 swset reads zero", d, 32'h0);
    wr_reg(3'd1, 32'h0); wr_reg(3'd4, 32'h0); wr_reg(3'd5, 32'h0);
    for (int i = 0; i < 16; i++) lv[i] = 4'h0;
  endtask

  task automatic t_ext_level;
    set_lvl(2, 4'd5);
    wr_reg(3'd1, 32'h0004);
    ext_irq[2] = 1'b0;
    tick(1);
    chk_pend("R3 one clock not yet", 2, 1'b0);
    tick(1);
    chk_pend("R3 level pending", 2, 1'b1);
    chk("R3 level code", {28'b0, irq_level}, 32'd5);
    wr_reg(3'd2, 32'h0004);
    chk_pend("R6 w1c no effect on level", 2, 1'b1);
    ext_irq[2] = 1'b1;
    tick(2);
    chk_pend("R3 level released", 2, 1'b0);
    chk("R3 request drops", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_low_level;
    set_lvl(7, 4'd9);
    wr_reg(3'd1, 32'h0080);
    wr_reg(3'd0, 32'h3F);
    low_n[1] = 1'b0;
    tick(2);
    chk_pend("R4 low line active", 7, 1'b1);
    chk("R4 low line code", {28'b0, irq_level}, 32'd9);
    low_n[1] = 1'b1;
    tick(2);
    chk_pend("R4 low line released", 7, 1'b0);
    wr_reg(3'd0, 32'h0);
  endtask

  task automatic t_ext_edge;
    set_lvl(0, 4'd3);
    wr_reg(3'd1, 32'h0001);
    wr_reg(3'd0, 32'h01);
    ext_irq[0] = 1'b0;
    tick(4);
    chk_pend("R5 low pin in edge style ignored", 0, 1'b0);
    ext_irq[0] = 1'b1;
    tick(2);
    chk_pend("R5 not latched at two clocks", 0, 1'b0);
    tick(1);
    chk_pend("R5 latched at three clocks", 0, 1'b1);
    ext_irq[0] = 1'b0;
    tick(3);
    chk_pend("R5 stays after pin falls", 0, 1'b1);
    chk("R5 edge code", {28'b0, irq_level}, 32'd3);
    wr_reg(3'd2, 32'h0001);
    chk_pend("R6 w1c clears edge bit", 0, 1'b0);
    ext_irq[0] = 1'b1;
    tick(4);
    wr_reg(3'd2, 32'h0001);
    wr_reg(3'd0, 32'h0);
  endtask

  task automatic t_retrigger;
    set_lvl(10, 4'd4);
    wr_reg(3'd1, 32'h0400);
    evt[0] = 1'b1; tick(1); evt[0] = 1'b0;
    chk_pend("R8 event latched after one clock", 10, 1'b1);
    tick(1);
    evt[0] = 1'b1; tick(1); evt[0] = 1'b0;
    tick(1);
    wr_reg(3'd2, 32'h0400);
    chk_pend("R7 edge while set not recorded", 10, 1'b0);
    evt[0] = 1'b1; tick(1); evt[0] = 1'b0;
    tick(1);
    evt[0] = 1'b1;
    wr_reg(3'd2, 32'h0400);
    evt[0] = 1'b0;
    chk_pend("R7 edge during clear lost", 10, 1'b0);
    tick(1);
    evt[0] = 1'b1; tick(1); evt[0] = 1'b0;
    chk_pend("R7 captures again after clear", 10, 1'b1);
    wr_reg(3'd2, 32'h0400);
  endtask

  task automatic t_evt_hold;
    evt[3] = 1'b1;
    tick(2);
    chk_pend("R8 held event latched", 13, 1'b1);
    wr_reg(3'd2, 32'h2000);
    tick(3);
    chk_pend("R8 held event latches once", 13, 1'b0);
    evt[3] = 1'b0;
    tick(1);
  endtask

  task automatic t_sw;
    set_lvl(14, 4'd2);
    set_lvl(15, 4'd11);
    wr_reg(3'd1, 32'hC000);
    wr_reg(3'd3, 32'h0000_0003);
    chk_pend("R9 sw0 set", 14, 1'b1);
    chk_pend("R9 sw1 set", 15, 1'b1);
    chk("R10 highest of two sw", {28'b0, irq_level}, 32'd11);
    wr_reg(3'd2, 32'h8000);
    chk("R10 next highest", {28'b0, irq_level}, 32'd2);
    wr_reg(3'd2, 32'h4000);
    chk("R9 sw cleared", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_priority;
    set_lvl(6, 4'd0);
    set_lvl(13, 4'd15);
    set_lvl(14, 4'd7);
    set_lvl(15, 4'd12);
    wr_reg(3'd1, 32'h0040);
    low_n[0] = 1'b0;
    tick(2);
    chk_pend("R10 code zero source pending", 6, 1'b1);
    chk("R10 code zero never requests", {31'b0, irq_req}, 32'h0);
    wr_reg(3'd1, 32'hE040);
    wr_reg(3'd3, 32'h3);
    chk("R10 max of 7 and 12", {28'b0, irq_level}, 32'd12);
    evt[3] = 1'b1; tick(1); evt[3] = 1'b0;
    chk("R10 code 15 wins", {28'b0, irq_level}, 32'd15);
    wr_reg(3'd2, 32'h2000);
    chk("R10 back to 12", {28'b0, irq_level}, 32'd12);
    wr_reg(3'd2, 32'h8000);
    chk("R10 down to 7", {28'b0, irq_level}, 32'd7);
    low_n[0] = 1'b1;
    tick(2);
  endtask

  task automatic t_mask;
    wr_reg(3'd1, 32'h0000);
    chk("R11 masked no request", {31'b0, irq_req}, 32'h0);
    chk_pend("R11 masked still pending", 14, 1'b1);
    wr_reg(3'd1, 32'h4000);
    chk("R11 unmasked level", {28'b0, irq_level}, 32'd7);
    wr_reg(3'd2, 32'h4000);
    wr_reg(3'd1, 32'h0);
  endtask

  task automatic t_nmi;
    nmi = 1'b1;
    tick(1);
    chk("R12 nmi not yet", {31'b0, nmi_req}, 32'h0);
    tick(1);
    chk("R12 nmi asserted", {31'b0, nmi_req}, 32'h1);
    chk("R12 nmi independent of irq", {31'b0, irq_req}, 32'h0);
    nmi = 1'b0;
    tick(2);
    chk("R12 nmi released", {31'b0, nmi_req}, 32'h0);
  endtask

  initial begin
    #20000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) lv[i] = 4'h0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regs();
    t_ext_level();
    t_low_level();
    t_ext_edge();
    t_retrigger();
    t_evt_hold();
    t_sw();
    t_priority();
    t_mask();
    t_nmi();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule